// File: doc/BRIEF.md
# Translation Table Base Register Bank

This block holds the base registers that software programs to describe two in-memory translation tables: a device table and a collection table. It sits behind a 0x40-byte register window of eight 64-bit slots, accepts 32-bit and 64-bit reads and writes, and keeps storage only for the first two slots. The other six slots read as zero and drop writes.

Every accepted write is first merged into the stored value. For a 32-bit write only the addressed half changes. The merged 64-bit value is then made legal before it is stored. The fixed descriptive fields (type, entry size, page size) are always rewritten. Read-only and unsupported bits are cleared, and attribute fields that are not supported are moved to supported encodings. Software that reads a slot back therefore sees exactly what the hardware will use. While the unit enable input is high the whole bank is frozen.

Top module: `tbase_bank`

## Requirements
- R1: The slot is byte offset bits 5:3. Slot 0 is the device table and slot 1 is the collection table. Slots 2 to 7 always read zero, and writes to them change no stored value.
- R2: While `unitEnable` is 1, writes change no stored value.
- R3: After a write, the entry-size field (bits 52:48) holds 7 and the type field (bits 58:56) holds 1 for slot 0 and 4 for slot 1, whatever was written there.
- R4: The indirect bit (bit 62) is always stored as 0 in slot 1. In slot 0 it keeps the written value.
- R5: Bits 15:12 are stored as 0. The page-size field (bits 9:8) is stored as 2 (64 KiB).
- R6: After reset, slot 0 reads 0x1907_0000_0000_0600 and slot 1 reads 0x1C07_0000_0000_0600. These values mean inner cacheability 3, outer cacheability 0, shareability 1, entry size 7, page size 2, plus the slot's type code.
- R7: Shareability (bits 11:10) keeps the values 0 and 1. The values 2 and 3 are stored as 1.
- R8: Inner cacheability (bits 61:59) and outer cacheability (bits 55:53) are stored unchanged for the values 0, 1, 3, 5 and 7. The write-through values 2, 4 and 6 are stored as 3, 5 and 7.
- R9: A 32-bit write (`wrWide`=0) takes its data from `wrData[31:0]`. It replaces the low half when offset bit 2 is 0 and the high half when offset bit 2 is 1; the other half is kept. The rules R3 to R8 then apply to the merged 64-bit value. All other bits (63, 47:16, 7:0) are stored as written.
- R10: Reads are combinational from `rdAddr` and show a write from the following clock edge onward. A 64-bit read (`rdWide`=1) returns the whole slot. A 32-bit read returns the half selected by offset bit 2 in `rdData[31:0]`, with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| unitEnable | input | 1 | Unit enable; freezes the bank when 1 |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 6 | Write byte offset in the window |
| wrWide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wrData | input | 64 | Write data |
| rdAddr | input | 6 | Read byte offset in the window |
| rdWide | input | 1 | 1 = 64-bit read, 0 = 32-bit read |
| rdData | output | 64 | Read data |

## Verification
An all-ones write to each implemented slot puts every forced field and every cleared field against the opposite value. It also separates the device slot from the collection slot through the indirect bit and the type code. Patterns that load write-through and reserved attribute codes show whether each cacheability field and the shareability field is remapped on its own. Two 32-bit writes in turn, to the low half and to the high half, separate a half-merge from a full overwrite. Writes to an unimplemented slot and writes made with the unit enabled must leave both stored slots unchanged.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int RegW     = 64;
  localparam int HalfW    = RegW / 2;
  localparam int NumSlots = 8;
  localparam int NumImpl  = 2;
  localparam int AddrW    = $clog2(NumSlots * (RegW / 8));
  localparam int SlotW    = $clog2(NumSlots);

  localparam logic [2:0] TypeDevice = 3'd1;
  localparam logic [2:0] TypeColl   = 3'd4;
  localparam logic [4:0] EntryEight = 5'd7;
  localparam logic [1:0] Page64k    = 2'd2;
  localparam logic [1:0] ShareInner = 2'd1;
  localparam logic [2:0] CacheRaWb  = 3'd3;

  typedef struct packed {
    logic [NumImpl-1:0] slotWr;
    logic               loEn;
    logic               hiEn;
  } wrStrobe_t;

  function automatic logic [2:0] slotTypeCode(input int idx);
    return (idx == 0) ? TypeDevice : TypeColl;
  endfunction

  // write-through encodings become their write-back neighbour
  function automatic logic [2:0] fixCache(input logic [2:0] c);
    return (c != 3'd0 && !c[0]) ? (c | 3'd1) : c;
  endfunction

  function automatic logic [RegW-1:0] legalise(input logic [RegW-1:0] v,
                                               input logic [2:0] typeCode,
                                               input logic clearIndirect);
    logic [RegW-1:0] r;
    r = v;
    r[58:56] = typeCode;
    r[52:48] = EntryEight;
    if (clearIndirect) r[62] = 1'b0;
    r[15:12] = 4'd0;
    r[9:8]   = Page64k;
    if (r[11]) r[11:10] = ShareInner;
    r[61:59] = fixCache(r[61:59]);
    r[55:53] = fixCache(r[55:53]);
    return r;
  endfunction

  function automatic logic [RegW-1:0] resetValue(input logic [2:0] typeCode);
    logic [RegW-1:0] r;
    r = '0;
    r[61:59] = CacheRaWb;
    r[58:56] = typeCode;
    r[52:48] = EntryEight;
    r[11:10] = ShareInner;
    r[9:8]   = Page64k;
    return r;
  endfunction
endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic             unitEnable,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic             wrWide,
  output wrStrobe_t        strobe
);
  logic [SlotW-1:0] wrSlot;
  logic             accept;

  assign wrSlot = wrAddr[AddrW-1:3];
  assign accept = wrEn && !unitEnable;

  for (genvar i = 0; i < NumImpl; i++) begin : g_dec
    assign strobe.slotWr[i] = accept && (wrSlot == SlotW'(i));
  end

  assign strobe.loEn = wrWide || !wrAddr[2];
  assign strobe.hiEn = wrWide ||  wrAddr[2];
endmodule

// File: rtl/tbase_datapath.sv
module tbase_datapath
  import tbase_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobe_t                 strobe,
  input  logic [RegW-1:0]           wrData,
  input  logic [AddrW-1:0]          rdAddr,
  input  logic                      rdWide,
  output logic [RegW-1:0]           rdData,
  output logic [NumImpl-1:0][RegW-1:0] slotVal
);
  logic [HalfW-1:0] newLo, newHi;
  logic [SlotW-1:0] rdSlot;
  logic [RegW-1:0]  rdFull;

  assign newLo = wrData[HalfW-1:0];
  assign newHi = strobe.loEn ? wrData[RegW-1:HalfW] : wrData[HalfW-1:0];

  for (genvar i = 0; i < NumImpl; i++) begin : g_slot
    localparam logic [2:0] TypeCode = slotTypeCode(i);
    localparam logic       ClrInd   = (i == 1);
    logic [RegW-1:0] merged;

    always_comb begin
      merged = slotVal[i];
      if (strobe.loEn) merged[HalfW-1:0]    = newLo;
      if (strobe.hiEn) merged[RegW-1:HalfW] = newHi;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 slotVal[i] <= resetValue(TypeCode);
      else if (strobe.slotWr[i]) slotVal[i] <= legalise(merged, TypeCode, ClrInd);
    end
  end

  assign rdSlot = rdAddr[AddrW-1:3];

  always_comb begin
    rdFull = '0;
    for (int i = 0; i < NumImpl; i++)
      if (rdSlot == SlotW'(i)) rdFull = slotVal[i];
    if (rdWide)         rdData = rdFull;
    else if (rdAddr[2]) rdData = {{HalfW{1'b0}}, rdFull[RegW-1:HalfW]};
    else                rdData = {{HalfW{1'b0}}, rdFull[HalfW-1:0]};
  end
endmodule

// File: rtl/tbase_bank.sv
module tbase_bank
  import tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             unitEnable,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic             wrWide,
  input  logic [RegW-1:0]  wrData,
  input  logic [AddrW-1:0] rdAddr,
  input  logic             rdWide,
  output logic [RegW-1:0]  rdData
);
  wrStrobe_t                    strobe;
  logic [NumImpl-1:0][RegW-1:0] slotVal;

  tbase_ctrl ctrl_i (
    .unitEnable(unitEnable), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrWide(wrWide), .strobe(strobe)
  );

  tbase_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdAddr(rdAddr), .rdWide(rdWide), .rdData(rdData), .slotVal(slotVal)
  );
endmodule

// File: rtl/tbase_bank_chk.sv
module tbase_bank_chk
  import tbase_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         unitEnable,
  input logic                         wrEn,
  input logic [AddrW-1:0]             wrAddr,
  input logic [AddrW-1:0]             rdAddr,
  input logic [RegW-1:0]              rdData,
  input logic [NumImpl-1:0][RegW-1:0] slotVal
);
  AST_LOCKED_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && unitEnable) |=> $stable(slotVal)); // R2
  AST_HIGH_SLOT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[AddrW-1:4] != '0) |=> $stable(slotVal)); // R1
  AST_HIGH_SLOT_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr[AddrW-1:4] != '0) |-> (rdData == '0)); // R1
  AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (slotVal[0][58:56] == 3'd1 && slotVal[1][58:56] == 3'd4 &&
     slotVal[0][52:48] == 5'd7 && slotVal[1][52:48] == 5'd7)); // R3
  AST_COLL_NO_INDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !slotVal[1][62]); // R4
  AST_PAGE_AND_HIGH_PA: assert property (@(posedge clk) disable iff (!rstN)
    (slotVal[0][9:8] == 2'd2 && slotVal[0][15:12] == 4'd0 &&
     slotVal[1][9:8] == 2'd2 && slotVal[1][15:12] == 4'd0)); // R5
  AST_SHARE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (!slotVal[0][11] && !slotVal[1][11])); // R7
  AST_CACHE_NO_WT: assert property (@(posedge clk) disable iff (!rstN)
    (!(slotVal[0][61:59] inside {3'd2, 3'd4, 3'd6}) &&
     !(slotVal[1][55:53] inside {3'd2, 3'd4, 3'd6}))); // R8
endmodule

bind tbase_bank tbase_bank_chk chk_i (
  .clk(clk), .rstN(rstN), .unitEnable(unitEnable), .wrEn(wrEn),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .rdData(rdData), .slotVal(slotVal)
);

// File: tb/tbase_bank_tb_top.sv
module tbase_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        unitEnable = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic        wrWide = 1'b0;
  logic [63:0] wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic        rdWide = 1'b1;
  logic [63:0] rdData;

  int vecCount = 0;
  int errCount = 0;
  logic [63:0] devM, collM;

  always #2.5 clk = ~clk;

  tbase_bank dut_i (.*);

  function automatic logic [2:0] wb(input logic [2:0] c);
    if (c == 3'd2 || c == 3'd4 || c == 3'd6) return c + 3'd1;
    return c;
  endfunction

  // expected stored value from the requirement text
  function automatic logic [63:0] expLegal(input logic [63:0] v, input bit coll);
    logic [63:0] r;
    r = v;
    r[58:56] = coll ? 3'd4 : 3'd1;            // R3
    r[52:48] = 5'd7;                          // R3
    if (coll) r[62] = 1'b0;                   // R4
    r[15:12] = 4'h0;                          // R5
    r[9:8]   = 2'd2;                          // R5
    if (r[11:10] >= 2'd2) r[11:10] = 2'd1;    // R7
    r[61:59] = wb(r[61:59]);                  // R8
    r[55:53] = wb(r[55:53]);                  // R8
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrWide = wide;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [5:0] a, input bit wide,
                         input logic [63:0] exp);
    rdAddr = a; rdWide = wide;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic modelWrite(input logic [5:0] a, input logic [63:0] d, input bit wide);
    logic [63:0] cur, m;
    if (unitEnable || a[5:4] != 2'd0) return;
    cur = a[3] ? collM : devM;
    m = cur;
    if (wide) m = d;
    else if (a[2]) m[63:32] = d[31:0];
    else m[31:0] = d[31:0];
    if (a[3]) collM = expLegal(m, 1'b1);
    else devM = expLegal(m, 1'b0);
  endtask

  task automatic wrAndModel(input logic [5:0] a, input logic [63:0] d, input bit wide);
    doWrite(a, d, wide);
    modelWrite(a, d, wide);
  endtask

  task automatic testReset();
    readChk("R6", 6'h00, 1'b1, 64'h1907_0000_0000_0600);
    readChk("R6", 6'h08, 1'b1, 64'h1C07_0000_0000_0600);
    readChk("R1", 6'h10, 1'b1, 64'h0);
  endtask

  task automatic testAllOnes();
    wrAndModel(6'h00, '1, 1'b1);
    readChk("R3", 6'h00, 1'b1, devM);
    check("R4", {63'd0, devM[62]}, 64'd1);
    wrAndModel(6'h08, '1, 1'b1);
    readChk("R4", 6'h08, 1'b1, collM);
    check("R4", {63'd0, collM[62]}, 64'd0);
    wrAndModel(6'h00, '0, 1'b1);
    readChk("R5", 6'h00, 1'b1, 64'h0107_0000_0000_0200);
  endtask

  task automatic testAttrs();
    // inner=2, outer=4, share=2
    wrAndModel(6'h00, {2'b10, 3'd2, 3'd0, 3'd4, 5'd0, 32'hABCD_1234, 4'hF, 2'd2, 2'd0, 8'h5A}, 1'b1);
    readChk("R8", 6'h00, 1'b1, devM);
    check("R8", {58'd0, devM[61:59], devM[55:53]}, {58'd0, 3'd3, 3'd5});
    check("R7", {62'd0, devM[11:10]}, 64'd1);
    // inner=6, outer=5, share=0 on collection slot
    wrAndModel(6'h08, {2'b00, 3'd6, 3'd0, 3'd5, 5'd0, 32'h0000_FFFF, 4'h3, 2'd0, 2'd0, 8'h01}, 1'b1);
    readChk("R8", 6'h08, 1'b1, collM);
    check("R7", {62'd0, collM[11:10]}, 64'd0);
    // share=3 -> 1
    wrAndModel(6'h08, 64'h0000_0000_0000_0C00, 1'b1);
    readChk("R7", 6'h08, 1'b1, collM);
  endtask

  task automatic testHalves();
    wrAndModel(6'h04, 64'hDEAD_BEEF_8000_0000, 1'b0); // high half from wrData[31:0]
    readChk("R9", 6'h00, 1'b1, devM);
    wrAndModel(6'h00, 64'h1111_1111_0000_F3FF, 1'b0);
    readChk("R9", 6'h00, 1'b1, devM);
    readChk("R10", 6'h00, 1'b0, {32'd0, devM[31:0]});
    readChk("R10", 6'h04, 1'b0, {32'd0, devM[63:32]});
    wrAndModel(6'h0C, 64'h0000_0000_4321_8765, 1'b0);
    readChk("R9", 6'h08, 1'b1, collM);
    readChk("R10", 6'h0C, 1'b0, {32'd0, collM[63:32]});
  endtask

  task automatic testIgnored();
    logic [63:0] d0, c0;
    d0 = devM; c0 = collM;
    doWrite(6'h18, '1, 1'b1);
    readChk("R1", 6'h18, 1'b1, 64'h0);
    readChk("R1", 6'h00, 1'b1, d0);
    readChk("R1", 6'h08, 1'b1, c0);
    doWrite(6'h3C, '1, 1'b0);
    readChk("R1", 6'h3C, 1'b0, 64'h0);
    readChk("R1", 6'h00, 1'b1, d0);
    unitEnable = 1'b1;
    doWrite(6'h00, 64'h0, 1'b1);
    doWrite(6'h08, 64'h0, 1'b1);
    readChk("R2", 6'h00, 1'b1, d0);
    readChk("R2", 6'h08, 1'b1, c0);
    unitEnable = 1'b0;
    wrAndModel(6'h08, 64'h0, 1'b1);
    readChk("R2", 6'h08, 1'b1, collM);
  endtask

  initial begin
    devM  = 64'h1907_0000_0000_0600;
    collM = 64'h1C07_0000_0000_0600;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllOnes();
    testAttrs();
    testHalves();
    testIgnored();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #100000;
    errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end
endmodule